// File: doc/BRIEF.md
# Scatter-Gather DMA Write Controller

The controller drains a 256-bit user data stream into a set of host-side destination buffers, such as system memory or GPU memory mapped on the bus. It issues write bursts on a simple bus-master write channel. The start address and the burst length travel with every beat, and ready/valid handshaking governs each beat. Destination buffers are described by a small table. Each entry holds a base address, a size and a valid flag. Host software loads the table through a programmed-I/O register port and may rewrite it between transfers, so data lands directly in user buffers with no bounce copy.

The host programs the transfer length, the maximum burst payload and a notification address, then writes the start command. The controller walks the table in index order. It splits every buffer into bursts that respect the payload limit and never cross a 4 KB page. When all data is out, it sends one completion beat to the notification address. The host answers with the stop command. A cycle counter records the start-to-stop round trip at one count per clock, so 4 ns per count at 250 MHz. Status registers report progress and faults.

All lengths, sizes and base addresses are assumed to be multiples of the 32-byte beat.

Top module: `sgdma_wr_ctrl`

## Requirements
- R1: After reset, busy, done and overflow read 0 (STATUS word 0x08, bits 0, 1 and 2), `m_valid` is 0 and `in_ready` is 0.
- R2: Input words leave on `m_data` unchanged and in arrival order. Bursts target consecutive addresses base+offset inside each buffer, and `m_last` marks the final beat of each burst.
- R3: Each data burst length `m_len` (in bytes) is at most the payload selected by CFG word 0x01 bits [1:0]: code 0 gives 128, code 1 gives 256, codes 2 and 3 give 512.
- R4: No data burst crosses a 4096-byte address boundary.
- R5: Table entries are used in rising index order. Entries with valid=0 or size 0 are skipped. After an entry is exhausted, the STATUS index field [15:8] moves to the following entry.
- R6: Writing a size above 0x8000_0000 to a table entry stores 0x8000_0000, and the stored value reads back through the register port.
- R7: After the last data beat, exactly one beat goes to the notification address with `m_note`=1, `m_last`=1 and `m_len`=32. Bits [31:0] of its data carry the total data bytes of the transfer.
- R8: If the table runs out before the programmed length is sent, the block stops with overflow=1 and busy=0. It sends no notification beat and does not set done.
- R9: `in_ready` is high only while `m_ready` is high, and a stalled beat keeps its address and length.
- R10: Done rises only when the notification beat is accepted. It is cleared by CTRL bit 2 or by the stop command. Busy and done are never both set.
- R11: The RTT register (word 0x0A) equals the number of clock edges from the accepted start command to the stop command.
- R12: The BYTES register (word 0x09) holds the count of data bytes written in the current or last transfer.
- R13: A start command written while busy has no effect on the transfer or on the round-trip counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| in_valid | input | 1 | Input stream word valid |
| in_ready | output | 1 | Input stream word accepted |
| in_data | input | 256 | Input stream word |
| m_valid | output | 1 | Write beat valid |
| m_ready | input | 1 | Write beat accepted |
| m_addr | output | 64 | Burst start address |
| m_len | output | 16 | Burst length in bytes |
| m_data | output | 256 | Beat data |
| m_last | output | 1 | Final beat of burst |
| m_note | output | 1 | Beat is the completion notification |

Register map: 0x00 CTRL (write bit0 start, bit1 stop, bit2 clear done), 0x01 CFG, 0x02/0x03 notification address low/high, 0x04 transfer length, 0x08 STATUS, 0x09 BYTES, 0x0A RTT. Table entry i sits at 0x40+4i, with fields +0 base low, +1 base high, +2 size and +3 valid (bit 0).

## Verification
On every cycle, the assertions check the page-boundary and payload limits of each beat, the stability of a stalled beat, and that stream data is never taken without a downstream acceptance. They also check that done rises only right after an accepted notification and never alongside busy. Only the bench scenarios can show the exact address and data sequence across buffers, the skipping of unusable entries, and the overflow stop. The same applies to the size clamp readback, the byte and index status values, and the round-trip count, which depend on whole-transfer history.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_DATA = 2'd2,
    ST_NOTE = 2'd3
  } eng_state_e;

  localparam logic [7:0] RA_CTRL   = 8'h00;
  localparam logic [7:0] RA_CFG    = 8'h01;
  localparam logic [7:0] RA_NOTE_L = 8'h02;
  localparam logic [7:0] RA_NOTE_H = 8'h03;
  localparam logic [7:0] RA_LEN    = 8'h04;
  localparam logic [7:0] RA_STAT   = 8'h08;
  localparam logic [7:0] RA_BYTES  = 8'h09;
  localparam logic [7:0] RA_RTT    = 8'h0A;
  localparam logic [1:0] RA_TBL_HI = 2'b01;

  function automatic logic [31:0] payload_bytes(input logic [1:0] code);
    case (code)
      2'd0:    payload_bytes = 32'd128;
      2'd1:    payload_bytes = 32'd256;
      default: payload_bytes = 32'd512;
    endcase
  endfunction

endpackage

// File: rtl/sgdma_desc_table.sv
module sgdma_desc_table #(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 64,
  parameter int LEN_W    = 32,
  parameter int IDX_W    = 4,
  parameter logic [31:0] SIZE_CAP = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [1:0]        wr_field,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        pio_idx,
  input  logic [1:0]        pio_field,
  output logic [31:0]       pio_data,
  input  logic [IDX_W-1:0]  eng_idx,
  output logic [ADDR_W-1:0] eng_base,
  output logic [LEN_W-1:0]  eng_size,
  output logic              eng_valid
);

  logic [ADDR_W-1:0] ent_base [DEPTH];
  logic [LEN_W-1:0]  ent_size [DEPTH];
  logic [DEPTH-1:0]  ent_vld;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [ADDR_W-1:0] base_q, base_d;
    logic [LEN_W-1:0]  size_q, size_d;
    logic              vld_q, vld_d;
    logic              sel;

    assign sel = wr_en && (wr_idx == 4'(i));

    always_comb begin
      base_d = base_q;
      size_d = size_q;
      vld_d  = vld_q;
      if (sel) begin
        case (wr_field)
          2'd0: base_d[31:0] = wr_data;
          2'd1: base_d[ADDR_W-1:32] = wr_data[ADDR_W-33:0];
          2'd2: size_d = (wr_data > SIZE_CAP) ? LEN_W'(SIZE_CAP) : LEN_W'(wr_data);
          default: vld_d = wr_data[0];
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        size_q <= '0;
        vld_q  <= 1'b0;
      end else if (sel) begin
        base_q <= base_d;
        size_q <= size_d;
        vld_q  <= vld_d;
      end
    end

    assign ent_base[i] = base_q;
    assign ent_size[i] = size_q;
    assign ent_vld[i]  = vld_q;
  end

  always_comb begin
    eng_base  = '0;
    eng_size  = '0;
    eng_valid = 1'b0;
    if (eng_idx < IDX_W'(DEPTH)) begin
      eng_base  = ent_base[eng_idx];
      eng_size  = ent_size[eng_idx];
      eng_valid = ent_vld[eng_idx];
    end
  end

  always_comb begin
    pio_data = '0;
    if (pio_idx < 4'(DEPTH)) begin
      case (pio_field)
        2'd0:    pio_data = ent_base[pio_idx][31:0];
        2'd1:    pio_data = 32'(ent_base[pio_idx][ADDR_W-1:32]);
        2'd2:    pio_data = 32'(ent_size[pio_idx]);
        default: pio_data = {31'd0, ent_vld[pio_idx]};
      endcase
    end
  end

endmodule

// File: rtl/sgdma_rtt_timer.sv
module sgdma_rtt_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  output logic [CNT_W-1:0] count
);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
      if (stop) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/sgdma_burst_engine.sv
module sgdma_burst_engine
  import sgdma_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 4,
  parameter int BLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              done_clr,
  input  logic [1:0]        pl_code,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [ADDR_W-1:0] note_addr,
  output logic              start_acc,
  output logic [IDX_W-1:0]  tbl_idx,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [LEN_W-1:0]  tbl_size,
  input  logic              tbl_valid,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [BLEN_W-1:0] m_len,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic              m_note,
  output logic              busy,
  output logic              done,
  output logic              ovf,
  output logic [LEN_W-1:0]  bytes
);

  localparam int BEAT_B  = DATA_W / 8;
  localparam int BEAT_SH = $clog2(BEAT_B);
  localparam int PAGE_B  = 4096;

  eng_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LEN_W-1:0]  off_q, off_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  bytes_q, bytes_d;
  logic [ADDR_W-1:0] baddr_q, baddr_d;
  logic [BLEN_W-1:0] blen_q, blen_d;
  logic [BLEN_W-1:0] beats_q, beats_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              ovf_q, ovf_d;

  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  ent_left, to_page, pl_len, blen_c;
  logic [LEN_W-1:0]  new_off;
  logic              fire;

  // burst sizing: smallest of payload limit, entry remainder, transfer remainder, page room
  always_comb begin
    cur_addr = tbl_base + ADDR_W'(off_q);
    ent_left = tbl_size - off_q;
    to_page  = LEN_W'(PAGE_B) - LEN_W'(cur_addr[11:0]);
    pl_len   = LEN_W'(payload_bytes(pl_code));
    blen_c   = pl_len;
    if (ent_left < blen_c) blen_c = ent_left;
    if (rem_q    < blen_c) blen_c = rem_q;
    if (to_page  < blen_c) blen_c = to_page;
  end

  assign fire    = (state_q == ST_DATA) && in_valid && m_ready;
  assign new_off = off_q + LEN_W'(blen_q);

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    off_d     = off_q;
    rem_d     = rem_q;
    bytes_d   = bytes_q;
    baddr_d   = baddr_q;
    blen_d    = blen_q;
    beats_d   = beats_q;
    busy_d    = busy_q;
    done_d    = done_q;
    ovf_d     = ovf_q;
    start_acc = 1'b0;
    if (done_clr) done_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          start_acc = 1'b1;
          state_d   = ST_SEEK;
          idx_d     = '0;
          off_d     = '0;
          rem_d     = xfer_len;
          bytes_d   = '0;
          busy_d    = 1'b1;
          done_d    = 1'b0;
          ovf_d     = 1'b0;
        end
      end
      ST_SEEK: begin
        if (rem_q == '0) begin
          state_d = ST_NOTE;
        end else if (idx_q >= IDX_W'(DEPTH)) begin
          ovf_d   = 1'b1;
          busy_d  = 1'b0;
          state_d = ST_IDLE;
        end else if (tbl_valid && (tbl_size > off_q)) begin
          baddr_d = cur_addr;
          blen_d  = BLEN_W'(blen_c);
          beats_d = BLEN_W'(blen_c >> BEAT_SH);
          state_d = ST_DATA;
        end else begin
          idx_d = idx_q + 1'b1;
          off_d = '0;
        end
      end
      ST_DATA: begin
        if (fire) begin
          beats_d = beats_q - 1'b1;
          if (beats_q == BLEN_W'(1)) begin
            rem_d   = rem_q - LEN_W'(blen_q);
            bytes_d = bytes_q + LEN_W'(blen_q);
            state_d = ST_SEEK;
            if (new_off >= tbl_size) begin
              idx_d = idx_q + 1'b1;
              off_d = '0;
            end else begin
              off_d = new_off;
            end
          end
        end
      end
      default: begin
        if (m_ready) begin
          busy_d  = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      off_q   <= '0;
      rem_q   <= '0;
      bytes_q <= '0;
      baddr_q <= '0;
      blen_q  <= '0;
      beats_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      off_q   <= off_d;
      rem_q   <= rem_d;
      bytes_q <= bytes_d;
      baddr_q <= baddr_d;
      blen_q  <= blen_d;
      beats_q <= beats_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      ovf_q   <= ovf_d;
    end
  end

  always_comb begin
    m_valid = 1'b0;
    m_addr  = '0;
    m_len   = '0;
    m_data  = '0;
    m_last  = 1'b0;
    m_note  = 1'b0;
    if (state_q == ST_DATA) begin
      m_valid = in_valid;
      m_addr  = baddr_q;
      m_len   = blen_q;
      m_data  = in_data;
      m_last  = (beats_q == BLEN_W'(1));
    end else if (state_q == ST_NOTE) begin
      m_valid = 1'b1;
      m_addr  = note_addr;
      m_len   = BLEN_W'(BEAT_B);
      m_data  = DATA_W'(bytes_q);
      m_last  = 1'b1;
      m_note  = 1'b1;
    end
  end

  assign in_ready = (state_q == ST_DATA) && m_ready;
  assign tbl_idx  = idx_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign ovf      = ovf_q;
  assign bytes    = bytes_q;

endmodule

// File: rtl/sgdma_wr_ctrl.sv
module sgdma_wr_ctrl
  import sgdma_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int DEPTH  = 8,
  parameter int BLEN_W = 16,
  parameter int RTT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [BLEN_W-1:0] m_len,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic              m_note
);

  localparam int IDX_W = $clog2(DEPTH + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // register port decode
  logic wr_ctrl, wr_cfg, wr_nl, wr_nh, wr_len, wr_tbl;
  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_cfg  = reg_wr && (reg_addr == RA_CFG);
  assign wr_nl   = reg_wr && (reg_addr == RA_NOTE_L);
  assign wr_nh   = reg_wr && (reg_addr == RA_NOTE_H);
  assign wr_len  = reg_wr && (reg_addr == RA_LEN);
  assign wr_tbl  = reg_wr && (reg_addr[7:6] == RA_TBL_HI);

  logic cmd_start, cmd_stop, cmd_clr;
  assign cmd_start = wr_ctrl && reg_wdata[0];
  assign cmd_stop  = wr_ctrl && reg_wdata[1];
  assign cmd_clr   = wr_ctrl && (reg_wdata[2] || reg_wdata[1]);

  logic [1:0]        pl_q, pl_d;
  logic [ADDR_W-1:0] note_q, note_d;
  logic [LEN_W-1:0]  len_q, len_d;

  always_comb begin
    pl_d   = pl_q;
    note_d = note_q;
    len_d  = len_q;
    if (wr_cfg) pl_d = reg_wdata[1:0];
    if (wr_nl)  note_d[31:0] = reg_wdata;
    if (wr_nh)  note_d[ADDR_W-1:32] = reg_wdata[ADDR_W-33:0];
    if (wr_len) len_d = LEN_W'(reg_wdata);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pl_q   <= '0;
      note_q <= '0;
      len_q  <= '0;
    end else if (wr_cfg || wr_nl || wr_nh || wr_len) begin
      pl_q   <= pl_d;
      note_q <= note_d;
      len_q  <= len_d;
    end
  end

  logic [IDX_W-1:0]  tbl_idx;
  logic [ADDR_W-1:0] tbl_base;
  logic [LEN_W-1:0]  tbl_size;
  logic              tbl_valid;
  logic [31:0]       tbl_rdata;

  sgdma_desc_table #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .IDX_W (IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_tbl),
    .wr_idx   (reg_addr[5:2]),
    .wr_field (reg_addr[1:0]),
    .wr_data  (reg_wdata),
    .pio_idx  (reg_addr[5:2]),
    .pio_field(reg_addr[1:0]),
    .pio_data (tbl_rdata),
    .eng_idx  (tbl_idx),
    .eng_base (tbl_base),
    .eng_size (tbl_size),
    .eng_valid(tbl_valid)
  );

  logic             start_acc;
  logic             sts_busy, sts_done, sts_ovf;
  logic [LEN_W-1:0] sts_bytes;

  sgdma_burst_engine #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .BLEN_W(BLEN_W)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (cmd_start),
    .done_clr (cmd_clr),
    .pl_code  (pl_q),
    .xfer_len (len_q),
    .note_addr(note_q),
    .start_acc(start_acc),
    .tbl_idx  (tbl_idx),
    .tbl_base (tbl_base),
    .tbl_size (tbl_size),
    .tbl_valid(tbl_valid),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_addr   (m_addr),
    .m_len    (m_len),
    .m_data   (m_data),
    .m_last   (m_last),
    .m_note   (m_note),
    .busy     (sts_busy),
    .done     (sts_done),
    .ovf      (sts_ovf),
    .bytes    (sts_bytes)
  );

  logic [RTT_W-1:0] rtt_cnt;

  sgdma_rtt_timer #(.CNT_W(RTT_W)) u_rtt (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .start(start_acc),
    .stop (cmd_stop),
    .count(rtt_cnt)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[7:6] == RA_TBL_HI) begin
      reg_rdata = tbl_rdata;
    end else begin
      case (reg_addr)
        RA_CFG:    reg_rdata = {30'd0, pl_q};
        RA_NOTE_L: reg_rdata = note_q[31:0];
        RA_NOTE_H: reg_rdata = 32'(note_q[ADDR_W-1:32]);
        RA_LEN:    reg_rdata = 32'(len_q);
        RA_STAT:   reg_rdata = {16'd0, 8'(tbl_idx), 5'd0, sts_ovf, sts_done, sts_busy};
        RA_BYTES:  reg_rdata = 32'(sts_bytes);
        RA_RTT:    reg_rdata = 32'(rtt_cnt);
        default:   reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/sgdma_wr_ctrl_chk.sv
module sgdma_wr_ctrl_chk #(
  parameter int ADDR_W = 64,
  parameter int BLEN_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic [ADDR_W-1:0] m_addr,
  input logic [BLEN_W-1:0] m_len,
  input logic              m_note,
  input logic              in_ready,
  input logic              busy,
  input logic              done
);

  assert_len_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_len <= BLEN_W'(512)) && (m_len != '0));

  assert_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_note) |-> ((17'(m_addr[11:0]) + 17'(m_len)) <= 17'd4096));

  assert_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (m_ready && !m_note));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> ($stable(m_addr) && $stable(m_len)));

  assert_done_after_note_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(m_valid && m_ready && m_note));

  assert_busy_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

endmodule

bind sgdma_wr_ctrl sgdma_wr_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .BLEN_W(BLEN_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_addr  (m_addr),
  .m_len   (m_len),
  .m_note  (m_note),
  .in_ready(in_ready),
  .busy    (sts_busy),
  .done    (sts_done)
);

// File: tb/sgdma_wr_ctrl_tb_top.sv
module sgdma_wr_ctrl_tb_top;

  localparam int DEPTH = 8;

  logic         clk;
  logic         rst_n;
  logic         reg_wr;
  logic [7:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         in_valid;
  logic         in_ready;
  logic [255:0] in_data;
  logic         m_valid;
  logic         m_ready;
  logic [63:0]  m_addr;
  logic [15:0]  m_len;
  logic [255:0] m_data;
  logic         m_last;
  logic         m_note;

  sgdma_wr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_len(m_len),
    .m_data(m_data), .m_last(m_last), .m_note(m_note)
  );

  typedef struct {
    logic [63:0]  addr;
    int unsigned  len;
    logic [255:0] data;
    bit           last;
    bit           note;
  } beat_t;

  beat_t exp_q[$];

  int          checks = 0;
  int          fails  = 0;
  int unsigned cyc    = 0;
  int unsigned seq    = 0;
  int          bp_mode = 0;
  bit          stream_on = 0;

  logic [63:0] sh_base  [DEPTH];
  int unsigned sh_size  [DEPTH];
  bit          sh_valid [DEPTH];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // driver of stream data and downstream ready, plus scoreboard monitor
  always begin
    @(negedge clk);
    in_data = {8{seq}};
    m_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    #3;
    if (stream_on && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 R8 unexpected beat", m_addr, 64'h0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        check(m_addr == e.addr, "R2 R4 R7 beat address", m_addr, e.addr);
        check(32'(m_len) == e.len, "R3 R4 R7 beat length", 64'(m_len), 64'(e.len));
        check(m_data == e.data, "R2 R7 beat data", m_data[63:0], e.data[63:0]);
        check(m_last == e.last && m_note == e.note, "R2 R7 last/note flags",
              {62'd0, m_last, m_note}, {62'd0, e.last, e.note});
      end
    end
    if (in_valid && in_ready) begin
      check(m_ready, "R9 input taken during stall", 64'(m_ready), 64'd1);
      seq++;
    end
  end

  task automatic pio_wr(input logic [7:0] a, input logic [31:0] d, output int unsigned at);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 at = cyc;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pio_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tbl_set(input int i, input logic [63:0] base, input logic [31:0] size, input bit v);
    int unsigned t;
    pio_wr(8'h40 + 8'(4*i), base[31:0], t);
    pio_wr(8'h41 + 8'(4*i), base[63:32], t);
    pio_wr(8'h42 + 8'(4*i), size, t);
    pio_wr(8'h43 + 8'(4*i), {31'd0, v}, t);
    sh_base[i]  = base;
    sh_size[i]  = (size > 32'h8000_0000) ? 32'h8000_0000 : size;
    sh_valid[i] = v;
  endtask

  // expected beats from the requirements: table order, payload, page and remainder limits
  task automatic plan_xfer(input int unsigned len, input int unsigned pl, input logic [63:0] na,
                           output bit ovf, output int unsigned nbytes);
    int unsigned rem, s, off, bl, room;
    logic [63:0] a;
    beat_t b;
    rem = len; s = seq; nbytes = 0; ovf = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!sh_valid[i]) continue;
      off = 0;
      while (off < sh_size[i] && rem > 0) begin
        a = sh_base[i] + 64'(off);
        bl = pl;
        if (sh_size[i] - off < bl) bl = sh_size[i] - off;
        if (rem < bl) bl = rem;
        room = 4096 - int'(a[11:0]);
        if (room < bl) bl = room;
        for (int k = 0; k < int'(bl / 32); k++) begin
          b.addr = a; b.len = bl; b.data = {8{s}};
          b.last = (k == int'(bl / 32) - 1); b.note = 0;
          exp_q.push_back(b);
          s++;
        end
        off += bl; rem -= bl; nbytes += bl;
      end
    end
    if (rem > 0) ovf = 1;
    else begin
      b.addr = na; b.len = 32; b.data = 256'(nbytes); b.last = 1; b.note = 1;
      exp_q.push_back(b);
    end
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int n = 0; n < 5000; n++) begin
      pio_rd(8'h08, st);
      if (!st[0]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int unsigned t_start, t_stop, t;
    bit          ovf;
    int unsigned nb;

    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    in_valid = 1'b0; m_ready = 1'b0; in_data = '0;
    for (int i = 0; i < DEPTH; i++) begin sh_base[i] = '0; sh_size[i] = 0; sh_valid[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    pio_rd(8'h08, rd);
    check(rd[2:0] == 3'b000, "R1 status after reset", 64'(rd), 64'd0);
    check(m_valid == 1'b0, "R1 m_valid after reset", 64'(m_valid), 64'd0);
    check(in_ready == 1'b0, "R1 in_ready after reset", 64'(in_ready), 64'd0);

    in_valid = 1'b1;
    stream_on = 1;

    // R6 size clamp
    tbl_set(3, 64'h0000_0000_0005_0000, 32'hFFFF_FFFF, 0);
    pio_rd(8'h4E, rd);
    check(rd == 32'h8000_0000, "R6 clamped size readback", 64'(rd), 64'h8000_0000);

    // transfer A: payload code 3, page split, invalid entry skipped, backpressure
    tbl_set(0, 64'h0000_0000_0000_0F00, 32'd1024, 1);
    tbl_set(1, 64'h0000_0000_0009_0000, 32'd4096, 0);
    tbl_set(2, 64'h0000_0002_0000_0000, 32'd64, 1);
    pio_wr(8'h01, 32'd3, t);
    pio_wr(8'h02, 32'hCAFE_0040, t);
    pio_wr(8'h03, 32'h0000_0001, t);
    pio_wr(8'h04, 32'd1088, t);
    bp_mode = 1;
    plan_xfer(1088, 512, 64'h0000_0001_CAFE_0040, ovf, nb);
    pio_wr(8'h00, 32'h1, t_start);
    pio_wr(8'h00, 32'h1, t);  // R13 second start while busy must be ignored
    wait_idle();
    check(exp_q.size() == 0, "R13 R7 all beats of A delivered", 64'(exp_q.size()), 64'd0);
    pio_rd(8'h08, rd);
    check(rd[2:0] == 3'b010, "R10 done set after A", 64'(rd[2:0]), 64'd2);
    check(rd[15:8] == 8'd3, "R5 index after A", 64'(rd[15:8]), 64'd3);
    pio_rd(8'h09, rd);
    check(rd == nb, "R12 bytes after A", 64'(rd), 64'(nb));
    repeat (7) @(negedge clk);
    pio_wr(8'h00, 32'h2, t_stop);
    pio_rd(8'h0A, rd);
    check(rd == t_stop - t_start, "R11 R13 round trip count", 64'(rd), 64'(t_stop - t_start));
    pio_rd(8'h08, rd);
    check(rd[1] == 1'b0, "R10 done cleared by stop", 64'(rd[1]), 64'd0);

    // transfer B: payload code 0, zero-size entry skipped, table runs out
    bp_mode = 0;
    tbl_set(0, 64'h0000_0000_0000_4000, 32'd256, 1);
    tbl_set(1, 64'h0000_0000_0000_6000, 32'd0, 1);
    tbl_set(2, 64'h0000_0002_0000_0000, 32'd64, 0);
    pio_wr(8'h01, 32'd0, t);
    pio_wr(8'h04, 32'd512, t);
    plan_xfer(512, 128, 64'h0, ovf, nb);
    check(ovf == 1, "R8 model expects overflow", 64'(ovf), 64'd1);
    pio_wr(8'h00, 32'h1, t);
    wait_idle();
    check(exp_q.size() == 0, "R8 R5 all beats of B delivered", 64'(exp_q.size()), 64'd0);
    pio_rd(8'h08, rd);
    check(rd[2:0] == 3'b100, "R8 overflow set, busy and done clear", 64'(rd[2:0]), 64'd4);
    pio_rd(8'h09, rd);
    check(rd == 32'd256, "R12 bytes at overflow", 64'(rd), 64'd256);

    // transfer C: payload code 1, done cleared by CTRL bit 2
    bp_mode = 1;
    tbl_set(0, 64'h0000_0000_0000_8000, 32'd2048, 1);
    pio_wr(8'h01, 32'd1, t);
    pio_wr(8'h04, 32'd1024, t);
    plan_xfer(1024, 256, 64'h0000_0001_CAFE_0040, ovf, nb);
    pio_wr(8'h00, 32'h1, t);
    wait_idle();
    check(exp_q.size() == 0, "R3 all beats of C delivered", 64'(exp_q.size()), 64'd0);
    pio_rd(8'h08, rd);
    check(rd[2:0] == 3'b010, "R10 done set after C", 64'(rd[2:0]), 64'd2);
    pio_wr(8'h00, 32'h4, t);
    pio_rd(8'h08, rd);
    check(rd[1] == 1'b0, "R10 done cleared by clear bit", 64'(rd[1]), 64'd0);
    pio_rd(8'h09, rd);
    check(rd == 32'd1024, "R12 bytes after C", 64'(rd), 64'd1024);

    summary();
    $finish;
  end

endmodule